// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a list of write instructions kept in memory and replays each one as a register write on a local write port. Software programs three configuration registers through a simple write strobe. The control register holds an enable bit. The start register takes the byte address of the first instruction. The end register takes the byte address just past the last one. Writing the end register while the engine is enabled and idle launches the run. The engine then fetches 32-bit words, one at a time, over a request/valid memory port. It decodes instructions as dword pairs on 8-byte boundaries and issues writes through a valid/ready port until its fetch pointer reaches the end address.

There are two instruction forms, selected by bits 31:24 of the control dword. The single form (0x01) is a data dword followed by the control dword. The burst form (0x09) is a count dword, then the control dword, then that many data dwords, all sent to one register offset. A pair of all-zero dwords does nothing, so a list padded with zeros up to a 64-byte boundary runs cleanly. Any other opcode stops the run and raises a sticky error flag.

The sequencer moves through these states:
- S_IDLE goes to S_FETCH_LO on launch.
- S_FETCH_LO goes to S_FETCH_HI, and S_FETCH_HI goes to S_DECODE, each as its word returns.
- S_DECODE goes to S_PUT_ONE for a single write, to S_FETCH_DAT for a burst with a non-zero count, to S_NEXT for a zero pair or an empty burst, and back to S_IDLE on a bad opcode.
- S_PUT_ONE goes to S_NEXT once the write is accepted.
- S_FETCH_DAT goes to S_PUT_DAT when its word returns.
- S_PUT_DAT goes back to S_FETCH_DAT while data remains, and to S_NEXT after the last word. On that last step it skips the pad dword when needed.
- S_NEXT goes to S_IDLE when the pointer has reached the end address, and to S_FETCH_LO otherwise.

Top module: `cmdq_write_engine`

## Requirements
- R1: After reset, st_busy, st_error, st_enable, mem_req and rw_valid are all 0.
- R2: A single write is a pair: word 0 is the data and word 1 is {8'h01, be[3:0], offset[19:0]}. It produces exactly one write with rw_addr = offset, rw_be = be and rw_data = word 0.
- R3: A burst is a count word N, then {8'h09, 4'hx, offset[19:0]}, then N data words. It produces N writes to that same offset, with rw_be = 4'hF, in memory order.
- R4: When a burst has an odd N (an odd total dword count), the dword after its last data word is a pad. It is skipped, and the next instruction is decoded from the following 8-byte boundary, whatever the pad contains.
- R5: A pair of two zero dwords produces no write, and execution continues with the next pair.
- R6: A write of the end register (cfg_addr 2) launches a run only when the enable bit (bit 0 of cfg_addr 0) is set and the new end differs from the start register (cfg_addr 1). On launch, st_busy reads 1 right after that clock edge.
- R7: st_busy clears only after the fetch pointer has reached the end address and the last write has been accepted. rw_valid, rw_addr, rw_data and rw_be hold steady while rw_ready is low.
- R8: While st_busy is 1, writes to the control, start and end registers are ignored.
- R9: An opcode other than 0x01 or 0x09, in a pair that is not all zero, sets st_error, drops st_busy and stops fetching. st_error stays set until a write of 1 to control bit 1 while idle.
- R10: mem_req holds with a stable, 4-byte-aligned mem_addr until mem_rvalid. Fetches stay between the start and end addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 start address, 2 end address |
| cfg_wdata | input | 32 | Configuration write data |
| st_enable | output | 1 | Enable bit of the control register |
| st_busy | output | 1 | Run in progress |
| st_error | output | 1 | Sticky bad-opcode flag |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | ADDR_W | Byte address of the fetched word |
| mem_rvalid | input | 1 | Fetched word is valid |
| mem_rdata | input | 32 | Fetched word |
| rw_valid | output | 1 | Register write valid |
| rw_ready | input | 1 | Register write accepted |
| rw_addr | output | 20 | Register offset |
| rw_data | output | 32 | Register data |
| rw_be | output | 4 | Byte enables |

## Verification
The lists mix the cases so that failures point to different faults:
- Single writes with full and partial byte enables separate byte-enable decoding from data selection.
- An odd burst followed by a non-zero pad shows whether the pad is really skipped. An unskipped pad would misalign every later pair.
- An even burst followed at once by a single write shows that no pad is skipped when none exists.
- Zero pairs in the middle of the list and as end padding show the no-op rule.

Launches are tried with the engine disabled, with end equal to start, and with refused writes during a run followed by a relaunch that exposes which start address was kept. A list with a bad opcode between two valid writes shows where the engine stops and how the error flag clears. A throttled ready and a one-cycle memory latency exercise the handshakes throughout.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int WORD_W = 32;
    localparam int OFS_W  = 20;
    localparam int BE_W   = 4;

    localparam logic [7:0] OP_SINGLE = 8'h01;
    localparam logic [7:0] OP_BURST  = 8'h09;

    localparam logic [1:0] CSR_CTRL  = 2'd0;
    localparam logic [1:0] CSR_START = 2'd1;
    localparam logic [1:0] CSR_END   = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH_LO, S_FETCH_HI, S_DECODE,
        S_PUT_ONE, S_FETCH_DAT, S_PUT_DAT, S_NEXT
    } seq_state_e;

    typedef enum logic [1:0] { K_NOP, K_SINGLE, K_BURST, K_BAD } kind_e;
endpackage

// File: rtl/cmdq_csr.sv
module cmdq_csr
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              err_set,
    output logic              en_q,
    output logic              err_q,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic              launch
);
    logic              wr_ok;
    logic [ADDR_W-1:0] wr_ptr;
    logic              unused_cfg;

    assign wr_ok      = cfg_we && !busy;
    assign wr_ptr     = {cfg_wdata[ADDR_W-1:3], 3'b000};
    assign unused_cfg = ^{cfg_wdata[WORD_W-1:ADDR_W], cfg_wdata[2]};
    assign launch     = wr_ok && (cfg_addr == CSR_END) && en_q && (wr_ptr != start_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            start_q <= '0;
            end_q   <= '0;
        end else begin
            if (wr_ok && cfg_addr == CSR_CTRL) en_q    <= cfg_wdata[0];
            if (wr_ok && cfg_addr == CSR_START) start_q <= wr_ptr;
            if (wr_ok && cfg_addr == CSR_END)   end_q   <= wr_ptr;
            if (err_set)
                err_q <= 1'b1;
            else if (wr_ok && cfg_addr == CSR_CTRL && cfg_wdata[1])
                err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output kind_e             kind,
    output logic [OFS_W-1:0]  ofs,
    output logic [BE_W-1:0]   be
);
    assign ofs = hi_word[OFS_W-1:0];
    assign be  = hi_word[OFS_W+BE_W-1:OFS_W];

    always_comb begin
        if (lo_word == '0 && hi_word == '0)
            kind = K_NOP;
        else if (hi_word[WORD_W-1:WORD_W-8] == OP_SINGLE)
            kind = K_SINGLE;
        else if (hi_word[WORD_W-1:WORD_W-8] == OP_BURST)
            kind = K_BURST;
        else
            kind = K_BAD;
    end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic              busy,
    output logic              err_set,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rw_valid,
    input  logic              rw_ready,
    output logic [OFS_W-1:0]  rw_addr,
    output logic [WORD_W-1:0] rw_data,
    output logic [BE_W-1:0]   rw_be
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [WORD_W-1:0] lo_q, hi_q, dat_q;
    logic [LEN_W-1:0]  left_q;
    kind_e             kind;
    logic [OFS_W-1:0]  dec_ofs;
    logic [BE_W-1:0]   dec_be;

    cmdq_decode u_dec (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .kind    (kind),
        .ofs     (dec_ofs),
        .be      (dec_be)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (launch) state_d = S_FETCH_LO;
            S_FETCH_LO:  if (mem_rvalid) state_d = S_FETCH_HI;
            S_FETCH_HI:  if (mem_rvalid) state_d = S_DECODE;
            S_DECODE: begin
                unique case (kind)
                    K_NOP:    state_d = S_NEXT;
                    K_SINGLE: state_d = S_PUT_ONE;
                    K_BURST:  state_d = (lo_q[LEN_W-1:0] == '0) ? S_NEXT : S_FETCH_DAT;
                    K_BAD:    state_d = S_IDLE;
                endcase
            end
            S_PUT_ONE:   if (rw_ready) state_d = S_NEXT;
            S_FETCH_DAT: if (mem_rvalid) state_d = S_PUT_DAT;
            S_PUT_DAT:   if (rw_ready) state_d = (left_q == '0) ? S_NEXT : S_FETCH_DAT;
            S_NEXT:      state_d = (ptr_q >= end_addr) ? S_IDLE : S_FETCH_LO;
            default:     state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            dat_q  <= '0;
            left_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (launch) ptr_q <= start_addr;
                S_FETCH_LO: if (mem_rvalid) begin
                    lo_q  <= mem_rdata;
                    ptr_q <= ptr_q + STEP;
                end
                S_FETCH_HI: if (mem_rvalid) begin
                    hi_q  <= mem_rdata;
                    ptr_q <= ptr_q + STEP;
                end
                S_DECODE: left_q <= lo_q[LEN_W-1:0];
                S_FETCH_DAT: if (mem_rvalid) begin
                    dat_q  <= mem_rdata;
                    ptr_q  <= ptr_q + STEP;
                    left_q <= left_q - 1'b1;
                end
                S_PUT_DAT: if (rw_ready && left_q == '0 && ptr_q[2])
                    ptr_q <= ptr_q + STEP;   // skip the pad dword
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        mem_req  = (state_q == S_FETCH_LO) || (state_q == S_FETCH_HI) ||
                   (state_q == S_FETCH_DAT);
        mem_addr = ptr_q;
        rw_valid = (state_q == S_PUT_ONE) || (state_q == S_PUT_DAT);
        rw_addr  = dec_ofs;
        rw_data  = (state_q == S_PUT_ONE) ? lo_q : dat_q;
        rw_be    = (state_q == S_PUT_ONE) ? dec_be : {BE_W{1'b1}};
        err_set  = (state_q == S_DECODE) && (kind == K_BAD);
    end
endmodule

// File: rtl/cmdq_write_engine.sv
module cmdq_write_engine
    import cmdq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              st_enable,
    output logic              st_busy,
    output logic              st_error,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              rw_valid,
    input  logic              rw_ready,
    output logic [19:0]       rw_addr,
    output logic [31:0]       rw_data,
    output logic [3:0]        rw_be
);
    logic              launch;
    logic              err_set;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;

    cmdq_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .busy      (st_busy),
        .err_set   (err_set),
        .en_q      (st_enable),
        .err_q     (st_error),
        .start_q   (start_q),
        .end_q     (end_q),
        .launch    (launch)
    );

    cmdq_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .start_addr (start_q),
        .end_addr   (end_q),
        .busy       (st_busy),
        .err_set    (err_set),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rw_valid   (rw_valid),
        .rw_ready   (rw_ready),
        .rw_addr    (rw_addr),
        .rw_data    (rw_data),
        .rw_be      (rw_be)
    );
endmodule

// File: rtl/cmdq_write_engine_chk.sv
module cmdq_write_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              st_busy,
    input logic              st_error,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              rw_valid,
    input logic              rw_ready,
    input logic [19:0]       rw_addr,
    input logic [31:0]       rw_data,
    input logic [3:0]        rw_be,
    input logic [ADDR_W-1:0] start_q,
    input logic [ADDR_W-1:0] end_q
);
    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rw_valid && !rw_ready |=> rw_valid && $stable(rw_addr) && $stable(rw_data) && $stable(rw_be));

    a_r10_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    a_r10_fetch_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    a_r8_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
        st_busy && cfg_we && cfg_addr == 2'd1 |=> $stable(start_q));

    a_r8_end_refused: assert property (@(posedge clk) disable iff (!rst_n)
        st_busy && cfg_we && cfg_addr == 2'd2 |=> $stable(end_q));

    a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_error) |-> !st_busy && !mem_req);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_error && !(cfg_we && cfg_addr == 2'd0 && cfg_wdata[1] && !st_busy) |=> st_error);

    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !st_busy |-> !mem_req && !rw_valid);
endmodule

bind cmdq_write_engine cmdq_write_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .st_busy    (st_busy),
    .st_error   (st_error),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rw_valid   (rw_valid),
    .rw_ready   (rw_ready),
    .rw_addr    (rw_addr),
    .rw_data    (rw_data),
    .rw_be      (rw_be),
    .start_q    (start_q),
    .end_q      (end_q)
);

// File: tb/test_cmdq_write_engine.sv
`timescale 1ns/1ps
module test_cmdq_write_engine;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [1:0]        cfg_addr;
    logic [31:0]       cfg_wdata;
    logic              st_enable, st_busy, st_error;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid;
    logic [31:0]       mem_rdata;
    logic              rw_valid;
    logic              rw_ready;
    logic [19:0]       rw_addr;
    logic [31:0]       rw_data;
    logic [3:0]        rw_be;

    always #10 clk = ~clk;

    cmdq_write_engine #(.ADDR_W(ADDR_W)) i_cmdq_write_engine (.*);

    typedef struct {
        logic [19:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        string       req;
    } wr_t;

    wr_t         exp_q[$];
    logic [31:0] mem [0:255];
    int          n_checks = 0;
    int          n_fail = 0;
    int          fetch_bad = 0;
    int          win_lo = 0;
    int          win_hi = 0;
    bit          finished = 0;
    logic [7:0]  lfsr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: one-cycle latency, also tracks the fetch window
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= mem[mem_addr[9:2]];
            if (mem_req && !mem_rvalid &&
                (int'(mem_addr) < win_lo || int'(mem_addr) >= win_hi))
                fetch_bad++;
        end
    end

    // throttled write acceptance
    always @(posedge clk) begin
        if (!rst_n) begin
            lfsr     <= 8'h5A;
            rw_ready <= 1'b0;
        end else begin
            lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rw_ready <= lfsr[0] | lfsr[2];
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rw_valid && rw_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected write", {rw_addr, rw_data}, 64'h0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(rw_addr == e.a && rw_data == e.d && rw_be == e.be, e.req,
                    "write addr/data/be", {8'h0, rw_be, rw_addr, rw_data},
                    {8'h0, e.be, e.a, e.d});
            end
        end
    end

    function automatic logic [31:0] ctl(input logic [7:0] op, input logic [3:0] be,
                                        input logic [19:0] ofs);
        return {op, be, ofs};
    endfunction

    task automatic push(input logic [19:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string req);
        wr_t e;
        e.a = a; e.d = d; e.be = be; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int g = 0;
        while (st_busy && g < 3000) begin
            @(negedge clk);
            g++;
        end
        chk(!st_busy, req, "busy clears", {63'h0, st_busy}, 64'h0);
    endtask

    task automatic expect_list1();
        push(20'h00100, 32'hA5A5_0001, 4'hF, "R2");
        push(20'h00104, 32'h1234_5678, 4'h3, "R2");
        push(20'h00200, 32'h0000_0011, 4'hF, "R3");
        push(20'h00200, 32'h0000_0022, 4'hF, "R3");
        push(20'h00200, 32'h0000_0033, 4'hF, "R3");
        push(20'h00300, 32'hCAFE_0003, 4'hF, "R4");
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // list 1 at 0x000: single, single, odd burst + pad, zero pair, single, zero fill to 0x40
        mem[0]  = 32'hA5A5_0001; mem[1]  = ctl(8'h01, 4'hF, 20'h00100);
        mem[2]  = 32'h1234_5678; mem[3]  = ctl(8'h01, 4'h3, 20'h00104);
        mem[4]  = 32'd3;         mem[5]  = ctl(8'h09, 4'h0, 20'h00200);
        mem[6]  = 32'h11; mem[7] = 32'h22; mem[8] = 32'h33;
        mem[9]  = 32'hFFFF_FFFF;                       // pad with junk
        mem[12] = 32'hCAFE_0003; mem[13] = ctl(8'h01, 4'hF, 20'h00300);
        // list 2 at 0x100: even burst then single
        mem[64] = 32'd2;         mem[65] = ctl(8'h09, 4'h0, 20'h00410);
        mem[66] = 32'h77;        mem[67] = 32'h88;
        mem[68] = 32'h0000_BEEF; mem[69] = ctl(8'h01, 4'hC, 20'h00420);
        // list 3 at 0x200: single, bad opcode, single
        mem[128] = 32'h1;        mem[129] = ctl(8'h01, 4'hF, 20'h00500);
        mem[130] = 32'h0;        mem[131] = ctl(8'h05, 4'hF, 20'h00510);
        mem[132] = 32'h2;        mem[133] = ctl(8'h01, 4'hF, 20'h00600);

        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!st_busy && !st_error && !st_enable && !mem_req && !rw_valid, "R1",
            "reset outputs", {59'h0, st_busy, st_error, st_enable, mem_req, rw_valid}, 64'h0);

        // R6 disabled: end write does not launch
        cfg_wr(2'd1, 32'h0);
        cfg_wr(2'd2, 32'h40);
        chk(!st_busy, "R6", "no launch when disabled", {63'h0, st_busy}, 64'h0);
        repeat (10) @(negedge clk);
        chk(!st_busy && !st_enable, "R6", "still idle", {62'h0, st_busy, st_enable}, 64'h0);

        cfg_wr(2'd0, 32'h1);
        chk(st_enable, "R6", "enable bit", {63'h0, st_enable}, 64'h1);

        // list 1
        win_lo = 0; win_hi = 'h40;
        expect_list1();
        cfg_wr(2'd2, 32'h40);
        chk(st_busy, "R6", "busy after launch", {63'h0, st_busy}, 64'h1);
        wait_idle("R7");
        chk(exp_q.size() == 0, "R5", "all writes seen, zero pairs silent", exp_q.size(), 0);
        chk(!st_error, "R4", "pad skipped without error", {63'h0, st_error}, 64'h0);

        // R6 end equal to start: no launch
        cfg_wr(2'd2, 32'h0);
        chk(!st_busy, "R6", "end equals start", {63'h0, st_busy}, 64'h0);

        // list 2
        win_lo = 'h100; win_hi = 'h118;
        push(20'h00410, 32'h77, 4'hF, "R3");
        push(20'h00410, 32'h88, 4'hF, "R3");
        push(20'h00420, 32'h0000_BEEF, 4'hC, "R2");
        cfg_wr(2'd1, 32'h100);
        cfg_wr(2'd2, 32'h118);
        chk(st_busy, "R6", "busy after launch", {63'h0, st_busy}, 64'h1);
        wait_idle("R7");
        chk(exp_q.size() == 0, "R3", "even burst, no pad", exp_q.size(), 0);

        // R8 refusal while busy
        win_lo = 0; win_hi = 'h40;
        cfg_wr(2'd1, 32'h0);
        expect_list1();
        cfg_wr(2'd2, 32'h40);
        cfg_wr(2'd1, 32'h100);
        cfg_wr(2'd0, 32'h0);
        cfg_wr(2'd2, 32'h200);
        wait_idle("R8");
        chk(exp_q.size() == 0, "R8", "run ended at kept end", exp_q.size(), 0);
        chk(st_enable, "R8", "enable kept", {63'h0, st_enable}, 64'h1);
        expect_list1();
        cfg_wr(2'd2, 32'h40);
        chk(st_busy, "R8", "relaunch from kept start", {63'h0, st_busy}, 64'h1);
        wait_idle("R8");
        chk(exp_q.size() == 0, "R8", "kept start replayed", exp_q.size(), 0);

        // R9 bad opcode
        win_lo = 'h200; win_hi = 'h218;
        push(20'h00500, 32'h1, 4'hF, "R9");
        cfg_wr(2'd1, 32'h200);
        cfg_wr(2'd2, 32'h218);
        wait_idle("R9");
        chk(st_error, "R9", "error set", {63'h0, st_error}, 64'h1);
        repeat (10) begin
            @(negedge clk);
            chk(!mem_req && !st_busy, "R9", "fetching stopped", {62'h0, mem_req, st_busy}, 64'h0);
        end
        chk(exp_q.size() == 0, "R9", "only first write issued", exp_q.size(), 0);
        cfg_wr(2'd0, 32'h1);
        chk(st_error, "R9", "error sticky", {63'h0, st_error}, 64'h1);
        cfg_wr(2'd0, 32'h3);
        chk(!st_error && st_enable, "R9", "error cleared", {62'h0, st_error, st_enable}, 64'h1);

        chk(fetch_bad == 0, "R10", "fetches inside window", fetch_bad, 0);
        repeat (5) @(negedge clk);
        finish_test();
    end
endmodule